// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Array

This block models a small field-configurable AND-OR logic device. Twelve dedicated logic inputs and ten macrocell feedback signals form 22 array signals. Each array signal is offered to the AND plane in true and in complemented form. Every product term is one configuration row that chooses which of those 44 literals it ANDs. Each macrocell ORs its own group of product terms. The result goes to the output either directly or through a register, with a selectable inversion. A dedicated product term per macrocell drives that output's enable. Two shared product terms clear all registers and preset all registers.

The block runs on a single system clock `clk`. The registers do not take that clock as their capture event. They capture when logic input 0 is seen rising: its level is high at a `clk` edge and was low at the edge before. The same input is also an ordinary array signal. The configuration is written one word at a time through an address/data port and read back combinationally. The same port carries a register preload, a sticky security lock and a 64-bit user signature. Once the lock is set, configuration readback and preload stop working. The signature can still be read.

Top module: `sopLogicArray`

## Requirements
- R1: While `rst` is high, and right after it falls, every register holds 0, every mode bit is 0, and every configuration row reads back as all ones. Such a row evaluates to 0, so `ioOut` and `ioOe` are both 0.
- R2: Array signal k is `inPins[k]` for k below 12 and macrocell feedback k-12 for k from 12 to 21. Row bit 2k selects signal k true and row bit 2k+1 selects it complemented. A row's term is the AND of its selected literals: a row of all zeros gives 1, and a row that selects both forms of one signal gives 0.
- R3: Macrocells 0 to 9 own 8, 10, 12, 14, 16, 16, 14, 12, 10 and 8 sum terms. Their rows follow one another from address 0. Each macrocell's group starts with its enable row, followed by its sum rows. Row 130 is the clear term and row 131 the preset term.
- R4: The mode word at address 0xA0 holds the registered-select bits in [9:0] and the invert bits in [19:10]. For a combinational macrocell, `ioOut` is the OR of its sum terms, XORed with its invert bit, within the same cycle.
- R5: A registered macrocell loads its OR sum at a `clk` edge where `inPins[0]` is 1 and was 0 at the previous edge. Its `ioOut` is the register value XORed with the invert bit.
- R6: A registered macrocell feeds its register back into the array. A combinational macrocell feeds back its pad level `ioIn[i]`.
- R7: `ioOe[i]` equals macrocell i's enable term, evaluated combinationally.
- R8: When the clear term is 1 at a `clk` edge, all registers become 0 without any pin-clock rise. This overrides preset, preload and capture.
- R9: When the preset term is 1 at a pin-clock rise, and there is no clear or preload, all registers become 1.
- R10: A write to address 0xA1 loads data bits [9:0] into the registers at that edge, unless the lock is set. Preload overrides a pin-clock capture.
- R11: Writing 1 in data bit 0 to address 0xA2 sets the lock. The lock stays set until `rst`. Address 0xA2 reads the lock in bit 0. While locked, rows and the mode word read as 0 and preload has no effect.
- R12: Addresses 0xA3 and 0xA4 hold the low and high 32 signature bits. Both are writable, and both are readable whether or not the lock is set.
- R13: `cfgRdata` shows the word at `cfgAddr` in the same cycle: rows at 0 to 131, the mode word, the lock and the signature words. Every other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| inPins | input | 12 | Dedicated logic inputs; bit 0 also acts as the pin clock |
| ioIn | input | 10 | Pad levels of the macrocell pins, used as feedback when combinational |
| ioOut | output | 10 | Macrocell output values |
| ioOe | output | 10 | Per-macrocell output enable |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 8 | Configuration address |
| cfgWdata | input | 44 | Configuration write data |
| cfgRdata | output | 44 | Configuration read data |

## Verification
The bench builds the block with its default sizes: 12 inputs and 10 macrocells, giving 132 rows of 44 bits. This puts both 16-term macrocells, the last row of the 8-term end groups, and the clear and preset rows at 130 and 131 within reach. Its model works out the allocation and the term values on its own. Random inputs and pad levels then exercise combinational, inverted, registered and feedback paths together with rare clear pulses and frequent preset. Directed steps cover preload, locking and full readback.

// File: rtl/sopPkg.sv
package sopPkg;

  localparam int ADDR_MODE    = 160;
  localparam int ADDR_PRELOAD = 161;
  localparam int ADDR_LOCK    = 162;
  localparam int ADDR_SIG_LO  = 163;
  localparam int ADDR_SIG_HI  = 164;

  // Sum terms given to a macrocell: wider towards the middle of the row of cells
  function automatic int ptCount(input int idx, input int nMc);
    int edgeDist;
    edgeDist = (idx < nMc - 1 - idx) ? idx : nMc - 1 - idx;
    if (edgeDist > 4) edgeDist = 4;
    return 8 + 2 * edgeDist;
  endfunction

  // First row (the enable row) of a macrocell's group
  function automatic int rowBase(input int idx, input int nMc);
    int acc;
    acc = 0;
    for (int j = 0; j < idx; j++) acc += ptCount(j, nMc) + 1;
    return acc;
  endfunction

  // All macrocell groups plus the shared clear and preset rows
  function automatic int rowCount(input int nMc);
    return rowBase(nMc, nMc) + 2;
  endfunction

  typedef struct packed {
    logic rowWe;
    logic modeWe;
    logic preloadEn;
    logic pinClkRise;
  } sopCmd_t;

endpackage

// File: rtl/sopArray.sv
module sopArray
  import sopPkg::*;
#(
  parameter int NUM_IN = 12,
  parameter int NUM_MC = 10,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 2 * (NUM_IN + NUM_MC)
) (
  input  logic              clk,
  input  logic              rst,
  input  sopCmd_t           cmd,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [DATA_W-1:0] cfgWdata,
  input  logic [NUM_IN-1:0] inPins,
  input  logic [NUM_MC-1:0] ioIn,
  output logic [DATA_W-1:0] rowRdata,
  output logic [DATA_W-1:0] modeRdata,
  output logic [NUM_MC-1:0] ioOut,
  output logic [NUM_MC-1:0] ioOe
);

  localparam int SIG_N   = NUM_IN + NUM_MC;
  localparam int LIT_W   = 2 * SIG_N;
  localparam int ROWS    = rowCount(NUM_MC);
  localparam int RST_ROW = ROWS - 2;
  localparam int PRE_ROW = ROWS - 1;

  logic [LIT_W-1:0]  rowMem [ROWS];
  logic [NUM_MC-1:0] regMode;
  logic [NUM_MC-1:0] invMode;
  logic [NUM_MC-1:0] qReg;
  logic [NUM_MC-1:0] fbVec;
  logic [NUM_MC-1:0] sumVec;
  logic [SIG_N-1:0]  sigVec;
  logic [LIT_W-1:0]  litVec;
  logic [ROWS-1:0]   termVec;

  // Configuration rows: erased state is all literals selected
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < ROWS; r++) rowMem[r] <= '1;
    end else if (cmd.rowWe) begin
      rowMem[cfgAddr] <= cfgWdata[LIT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      regMode <= '0;
      invMode <= '0;
    end else if (cmd.modeWe) begin
      {invMode, regMode} <= cfgWdata[2*NUM_MC-1:0];
    end
  end

  // Macrocell registers: clear > preload > pin-clock capture
  always_ff @(posedge clk) begin
    if (rst) begin
      qReg <= '0;
    end else if (termVec[RST_ROW]) begin
      qReg <= '0;
    end else if (cmd.preloadEn) begin
      qReg <= cfgWdata[NUM_MC-1:0];
    end else if (cmd.pinClkRise) begin
      qReg <= termVec[PRE_ROW] ? '1 : sumVec;
    end
  end

  assign fbVec  = (regMode & qReg) | (~regMode & ioIn);
  assign sigVec = {fbVec, inPins};

  for (genvar k = 0; k < SIG_N; k++) begin : gLit
    assign litVec[2*k]   = sigVec[k];
    assign litVec[2*k+1] = ~sigVec[k];
  end

  for (genvar r = 0; r < ROWS; r++) begin : gTerm
    assign termVec[r] = &(~rowMem[r] | litVec);
  end

  for (genvar g = 0; g < NUM_MC; g++) begin : gCell
    localparam int BASE = rowBase(g, NUM_MC);
    localparam int PTS  = ptCount(g, NUM_MC);
    assign ioOe[g]   = termVec[BASE];
    assign sumVec[g] = |termVec[BASE+1 +: PTS];
    assign ioOut[g]  = (regMode[g] ? qReg[g] : sumVec[g]) ^ invMode[g];
  end

  always_comb begin
    rowRdata = '0;
    if (int'(cfgAddr) < ROWS) rowRdata[LIT_W-1:0] = rowMem[cfgAddr];
    modeRdata = '0;
    modeRdata[2*NUM_MC-1:0] = {invMode, regMode};
  end

  assert_clear_wins_R8: assert property (@(posedge clk) disable iff (rst)
    termVec[RST_ROW] |=> (qReg == '0));

  assert_preset_sets_R9: assert property (@(posedge clk) disable iff (rst)
    (cmd.pinClkRise && termVec[PRE_ROW] && !termVec[RST_ROW] && !cmd.preloadEn)
    |=> (qReg == '1));

  assert_hold_between_R5: assert property (@(posedge clk) disable iff (rst)
    (!cmd.pinClkRise && !termVec[RST_ROW] && !cmd.preloadEn) |=> $stable(qReg));

endmodule

// File: rtl/sopCtrl.sv
module sopCtrl
  import sopPkg::*;
#(
  parameter int NUM_MC   = 10,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 44,
  parameter int SIG_HALF = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfgWe,
  input  logic [ADDR_W-1:0]   cfgAddr,
  input  logic [SIG_HALF-1:0] sigWdata,
  input  logic                pinClk,
  input  logic [DATA_W-1:0]   rowRdata,
  input  logic [DATA_W-1:0]   modeRdata,
  output sopCmd_t             cmd,
  output logic [DATA_W-1:0]   cfgRdata
);

  localparam int ROWS = rowCount(NUM_MC);

  logic                locked;
  logic                pinPrev;
  logic [SIG_HALF-1:0] sigLo;
  logic [SIG_HALF-1:0] sigHi;
  logic                isRow;
  logic                hitMode;
  logic                hitPreload;
  logic                hitLock;
  logic                hitSigLo;
  logic                hitSigHi;

  assign isRow      = int'(cfgAddr) < ROWS;
  assign hitMode    = cfgAddr == ADDR_W'(ADDR_MODE);
  assign hitPreload = cfgAddr == ADDR_W'(ADDR_PRELOAD);
  assign hitLock    = cfgAddr == ADDR_W'(ADDR_LOCK);
  assign hitSigLo   = cfgAddr == ADDR_W'(ADDR_SIG_LO);
  assign hitSigHi   = cfgAddr == ADDR_W'(ADDR_SIG_HI);

  always_ff @(posedge clk) begin
    if (rst) begin
      locked  <= 1'b0;
      pinPrev <= 1'b0;
      sigLo   <= '0;
      sigHi   <= '0;
    end else begin
      pinPrev <= pinClk;
      if (cfgWe && hitLock && sigWdata[0]) locked <= 1'b1;
      if (cfgWe && hitSigLo) sigLo <= sigWdata;
      if (cfgWe && hitSigHi) sigHi <= sigWdata;
    end
  end

  always_comb begin
    cmd.rowWe      = cfgWe && isRow;
    cmd.modeWe     = cfgWe && hitMode;
    cmd.preloadEn  = cfgWe && hitPreload && !locked;
    cmd.pinClkRise = pinClk && !pinPrev;
  end

  always_comb begin
    cfgRdata = '0;
    if (isRow)         cfgRdata = locked ? '0 : rowRdata;
    else if (hitMode)  cfgRdata = locked ? '0 : modeRdata;
    else if (hitLock)  cfgRdata = DATA_W'(locked);
    else if (hitSigLo) cfgRdata = DATA_W'(sigLo);
    else if (hitSigHi) cfgRdata = DATA_W'(sigHi);
  end

  assert_lock_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    locked |=> locked);

  assert_rise_is_single_R5: assert property (@(posedge clk) disable iff (rst)
    cmd.pinClkRise |=> !cmd.pinClkRise);

  assert_sig_kept_R12: assert property (@(posedge clk) disable iff (rst)
    !cfgWe |=> $stable({sigHi, sigLo}));

endmodule

// File: rtl/sopLogicArray.sv
module sopLogicArray
  import sopPkg::*;
#(
  parameter int NUM_IN   = 12,
  parameter int NUM_MC   = 10,
  parameter int ADDR_W   = 8,
  parameter int SIG_BITS = 64,
  parameter int DATA_W   = 2 * (NUM_IN + NUM_MC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_IN-1:0] inPins,
  input  logic [NUM_MC-1:0] ioIn,
  output logic [NUM_MC-1:0] ioOut,
  output logic [NUM_MC-1:0] ioOe,
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [DATA_W-1:0] cfgWdata,
  output logic [DATA_W-1:0] cfgRdata
);

  localparam int SIG_HALF = SIG_BITS / 2;

  sopCmd_t           cmd;
  logic [DATA_W-1:0] rowRdata;
  logic [DATA_W-1:0] modeRdata;

  sopCtrl #(
    .NUM_MC  (NUM_MC),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .SIG_HALF(SIG_HALF)
  ) ctrl (
    .clk      (clk),
    .rst      (rst),
    .cfgWe    (cfgWe),
    .cfgAddr  (cfgAddr),
    .sigWdata (cfgWdata[SIG_HALF-1:0]),
    .pinClk   (inPins[0]),
    .rowRdata (rowRdata),
    .modeRdata(modeRdata),
    .cmd      (cmd),
    .cfgRdata (cfgRdata)
  );

  sopArray #(
    .NUM_IN(NUM_IN),
    .NUM_MC(NUM_MC),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) array (
    .clk      (clk),
    .rst      (rst),
    .cmd      (cmd),
    .cfgAddr  (cfgAddr),
    .cfgWdata (cfgWdata),
    .inPins   (inPins),
    .ioIn     (ioIn),
    .rowRdata (rowRdata),
    .modeRdata(modeRdata),
    .ioOut    (ioOut),
    .ioOe     (ioOe)
  );

endmodule

// File: tb/sopLogicArray_test.sv
`timescale 1ns/1ps
module sopLogicArray_test;

  localparam int NR = 132;

  logic        clk = 1'b0;
  logic        rst;
  logic [11:0] inPins;
  logic [9:0]  ioIn;
  logic [9:0]  ioOut;
  logic [9:0]  ioOe;
  logic        cfgWe;
  logic [7:0]  cfgAddr;
  logic [43:0] cfgWdata;
  logic [43:0] cfgRdata;

  always #2 clk = ~clk;

  sopLogicArray uut (
    .clk(clk), .rst(rst), .inPins(inPins), .ioIn(ioIn), .ioOut(ioOut), .ioOe(ioOe),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata)
  );

  // Behavioural reference state
  logic [43:0] mRows [NR];
  logic [9:0]  mReg, mInv, mQ;
  logic        mLock, mPrev;
  logic [31:0] mSigLo, mSigHi;
  bit          started = 0;
  int          checks = 0;
  int          fails = 0;
  int          cyc = 0;
  string       phase = "R1";

  function automatic int ptOf(int i);
    return (i < 5) ? 8 + 2 * i : 8 + 2 * (9 - i);
  endfunction

  function automatic int baseOf(int i);
    int b = 0;
    for (int j = 0; j < i; j++) b += ptOf(j) + 1;
    return b;
  endfunction

  function automatic bit termOn(logic [43:0] row, logic [21:0] s);
    for (int k = 0; k < 22; k++) begin
      if (row[2*k] && !s[k]) return 0;
      if (row[2*k+1] && s[k]) return 0;
    end
    return 1;
  endfunction

  function automatic logic [21:0] sigsNow();
    logic [9:0] fb;
    for (int i = 0; i < 10; i++) fb[i] = mReg[i] ? mQ[i] : ioIn[i];
    return {fb, inPins};
  endfunction

  function automatic logic [9:0] sumsNow(logic [21:0] s);
    logic [9:0] r = '0;
    for (int i = 0; i < 10; i++)
      for (int t = 1; t <= ptOf(i); t++)
        if (termOn(mRows[baseOf(i) + t], s)) r[i] = 1'b1;
    return r;
  endfunction

  task automatic check(string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", phase, what, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // Model update on every clock edge
  always @(posedge clk) begin
    logic [21:0] s;
    logic [9:0]  sm, nq;
    bit          rT, pT, rise;
    started = 1;
    if (rst) begin
      for (int r = 0; r < NR; r++) mRows[r] = '1;
      mReg = '0; mInv = '0; mQ = '0; mLock = 0; mPrev = 0; mSigLo = '0; mSigHi = '0;
    end else begin
      s = sigsNow();
      sm = sumsNow(s);
      rT = termOn(mRows[130], s);
      pT = termOn(mRows[131], s);
      rise = inPins[0] && !mPrev;
      if (rT) nq = '0;
      else if (cfgWe && cfgAddr == 8'hA1 && !mLock) nq = cfgWdata[9:0];
      else if (rise) nq = pT ? 10'h3FF : sm;
      else nq = mQ;
      if (cfgWe) begin
        if (int'(cfgAddr) < NR) mRows[cfgAddr] = cfgWdata;
        else if (cfgAddr == 8'hA0) {mInv, mReg} = cfgWdata[19:0];
        else if (cfgAddr == 8'hA2 && cfgWdata[0]) mLock = 1;
        else if (cfgAddr == 8'hA3) mSigLo = cfgWdata[31:0];
        else if (cfgAddr == 8'hA4) mSigHi = cfgWdata[31:0];
      end
      mQ = nq;
      mPrev = inPins[0];
    end
  end

  // Compare away from the active edge
  always @(negedge clk) begin
    logic [21:0] s;
    logic [9:0]  sm, eo, ee;
    logic [43:0] er;
    if (started) begin
      s = sigsNow();
      sm = sumsNow(s);
      for (int i = 0; i < 10; i++) begin
        eo[i] = (mReg[i] ? mQ[i] : sm[i]) ^ mInv[i];
        ee[i] = termOn(mRows[baseOf(i)], s);
      end
      if (int'(cfgAddr) < NR) er = mLock ? '0 : mRows[cfgAddr];
      else if (cfgAddr == 8'hA0) er = mLock ? '0 : 44'({mInv, mReg});
      else if (cfgAddr == 8'hA2) er = 44'(mLock);
      else if (cfgAddr == 8'hA3) er = 44'(mSigLo);
      else if (cfgAddr == 8'hA4) er = 44'(mSigHi);
      else er = '0;
      check("ioOut", 64'(ioOut), 64'(eo));
      check("ioOe", 64'(ioOe), 64'(ee));
      check("cfgRdata", 64'(cfgRdata), 64'(er));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired in phase %s", phase);
      report();
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [43:0] d);
    cfgWe = 1'b1; cfgAddr = a; cfgWdata = d;
    tick();
    cfgWe = 1'b0;
  endtask

  task automatic randRun(int n);
    logic [31:0] rv;
    repeat (n) begin
      rv = $urandom; inPins = rv[11:0];
      rv = $urandom; inPins[5] = (rv[2:0] == 3'd0);
      rv = $urandom; ioIn = rv[9:0];
      rv = $urandom;
      cfgAddr = rv[31] ? 8'(rv[7:0] % 8'd140) : 8'(8'hA0 + rv[2:0] % 3'd5);
      tick();
    end
  endtask

  initial begin
    rst = 1'b1; inPins = '0; ioIn = '0; cfgWe = 1'b0; cfgAddr = 8'd0; cfgWdata = '0;
    phase = "R1";
    repeat (3) tick();
    rst = 1'b0;
    cfgAddr = 8'd5; tick();
    cfgAddr = 8'hA0; tick();

    phase = "R2";   // in1 & ~in2, and feedback of macrocell 1
    wr(8'd0, 44'd0);
    wr(8'd1, (44'd1 << 2) | (44'd1 << 5));
    wr(8'd2, 44'd1 << 26);
    wr(8'd3, (44'd1 << 6) | (44'd1 << 7));
    randRun(30);

    phase = "R4";
    wr(8'hA0, 44'd1 << 10);
    randRun(20);

    phase = "R3";   // widest group end row and last group end row
    wr(8'd48, 44'd0);
    wr(8'd64, 44'd0);
    wr(8'd121, 44'd0);
    wr(8'd129, 44'd1 << 14);
    randRun(15);

    phase = "R5";
    wr(8'd20, 44'd0);
    wr(8'd21, 44'd1 << 6);
    wr(8'hA0, (44'd1 << 10) | (44'd1 << 2));
    randRun(40);

    phase = "R6";
    wr(8'd33, 44'd0);
    wr(8'd34, 44'd1 << 28);
    wr(8'd9, 44'd0);
    wr(8'd10, 44'd1 << 26);
    randRun(30);

    phase = "R9";
    wr(8'd131, 44'd1 << 8);
    randRun(40);

    phase = "R8";
    wr(8'd130, 44'd1 << 10);
    randRun(40);

    phase = "R7";
    wr(8'd82, 44'd1 << 12);
    randRun(20);

    phase = "R10";
    inPins = '0; ioIn = '0;
    wr(8'hA1, 44'h2AA);
    cfgAddr = 8'hA0; tick(); tick();
    wr(8'hA1, 44'h155);
    tick();
    randRun(10);

    phase = "R13";
    for (int a = 0; a < 140; a++) begin
      cfgAddr = 8'(a); tick();
    end
    for (int a = 160; a < 168; a++) begin
      cfgAddr = 8'(a); tick();
    end

    phase = "R12";
    wr(8'hA3, 44'hC0FFEE12);
    wr(8'hA4, 44'h5A5A0001);
    cfgAddr = 8'hA3; tick();
    cfgAddr = 8'hA4; tick();

    phase = "R11";
    inPins = '0;
    wr(8'hA2, 44'd1);
    cfgAddr = 8'hA2; tick();
    wr(8'hA1, 44'h0F0);
    tick(); tick();
    for (int a = 0; a < 12; a++) begin
      cfgAddr = 8'(a); tick();
    end
    cfgAddr = 8'hA0; tick();
    cfgAddr = 8'hA3; tick();
    cfgAddr = 8'hA4; tick();
    randRun(20);

    report();
    $finish;
  end

endmodule